// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround Synchronous SRAM

This block is a single-port synchronous memory whose bus needs no idle cycle when the traffic switches between reads and writes. On each rising clock edge it takes an address, an operation type, byte-lane write enables and three chip selects. Read data flows out combinationally in the next cycle. Write data is taken from the bus in the next cycle. So a read can follow a write, or a write a read, on consecutive clocks.

Writes go through a one-entry staging register before they reach the array. A read of an address that is still staged returns the staged lanes merged over the array contents. A clock-enable input freezes the whole pipeline. An advance input steps the low address bits of the last loaded access, in linear order, for short bursts.

The bidirectional bus is split into an input word, an output word and a drive-enable. An enclosing pad ring or bus model joins them.

Top module: `zbt_ft_sram`

## Requirements
- R1: With `clk_en_n` low, `burst_adv` low and the device selected, a rising edge loads `addr`, `is_read` and `lane_we_n` as the new access. The access's data phase is the following cycle.
- R2: For a loaded read, during the next cycle `dq_out` equals the word stored at the loaded address, and `dq_drive` is high whenever `out_en_n` is low.
- R3: For a write, the lanes of `dq_in` present in the data phase are stored at the edge that ends that phase. `lane_we_n[i]` = 0, sampled with the access, enables lane i, which is bits [9i+8:9i]. Lanes with a 1 keep their old contents.
- R4: The device is selected only when `sel_a_n` = 0, `sel_b_n` = 0 and `sel_c` = 1. Any other combination on a load edge makes that cycle a deselect.
- R5: After a deselect edge, `dq_drive` is low for the whole following cycle.
- R6: Reads, writes and deselects may follow each other on consecutive edges with no idle cycle. A read loaded right after a write to the same address returns the newly written lanes merged over the old word.
- R7: During reset and after it, until a read has been loaded, `dq_drive` is low.
- R8: With `clk_en_n` high, an edge is ignored. The current data phase, including a write still waiting for its data, carries over unchanged to the next cycle.
- R9: With `burst_adv` high after a selected load, each enabled edge adds one, modulo 4, to the two low address bits. The upper bits and the operation type are kept, and `lane_we_n` is sampled anew. The chip selects are ignored on these edges.
- R10: With `burst_adv` high when the last load was a deselect, the device stays deselected.
- R11: `dq_drive` is low in any cycle where `out_en_n` is high, even during a read data phase. This has no effect on stored data or on the burst position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high freezes all state |
| sel_a_n | input | 1 | Active-low chip select |
| sel_b_n | input | 1 | Second active-low chip select |
| sel_c | input | 1 | Active-high chip select |
| addr | input | ADDR_W | Word address, sampled on load edges |
| is_read | input | 1 | 1 = read, 0 = write |
| burst_adv | input | 1 | 0 = load a new access, 1 = advance the burst |
| lane_we_n | input | LANES | Active-low byte-lane write enables |
| out_en_n | input | 1 | Active-low output enable (asynchronous) |
| dq_in | input | LANES*LANE_W | Bus value seen by the memory |
| dq_out | output | LANES*LANE_W | Read word of the current data phase |
| dq_drive | output | 1 | High when the memory drives the bus |

## Verification
The bench builds the block with a 4-bit address and the default four 9-bit lanes. With only 16 words, random addresses often repeat. Read-after-write forwarding from the staging register then happens often, and loads near a 4-word boundary often lead into bursts that wrap. Running thousands of random cycles against a small reference model exercises these cases, together with frozen edges that fall in the middle of a write.

// File: rtl/zbt_pkg.sv
`timescale 1ns/1ps
package zbt_pkg;

  typedef enum logic {
    OP_WRITE = 1'b0,
    OP_READ  = 1'b1
  } op_e;

  // Select holds only when both active-low selects are low and the active-high one is high.
  function automatic logic chip_sel(input logic sa_n, input logic sb_n, input logic sc);
    return !sa_n && !sb_n && sc;
  endfunction

endpackage

// File: rtl/zbt_ctrl.sv
`timescale 1ns/1ps
module zbt_ctrl #(
  parameter int AW      = 8,
  parameter int LANES   = 4,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              sel_a_n,
  input  logic              sel_b_n,
  input  logic              sel_c,
  input  logic [AW-1:0]     addr,
  input  logic              is_read,
  input  logic              burst_adv,
  input  logic [LANES-1:0]  lane_we_n,
  output logic              ph_valid,
  output zbt_pkg::op_e      ph_op,
  output logic [AW-1:0]     ph_addr,
  output logic [LANES-1:0]  ph_bw_n,
  output logic              burst_on,
  output logic              ev_desel
);
  import zbt_pkg::*;

  // Linear burst step: only the low BURST_W bits move, wrapping inside the group.
  function automatic logic [AW-1:0] burst_step(input logic [AW-1:0] a);
    logic [AW-1:0]      r;
    logic [BURST_W-1:0] lo;
    lo = a[BURST_W-1:0] + BURST_W'(1);
    r  = a;
    r[BURST_W-1:0] = lo;
    return r;
  endfunction

  logic sel_now;
  logic ev_load;
  logic ev_adv;
  logic ev_idle;

  assign sel_now  = chip_sel(sel_a_n, sel_b_n, sel_c);
  assign ev_load  = !clk_en_n && !burst_adv && sel_now;
  assign ev_desel = !clk_en_n && !burst_adv && !sel_now;
  assign ev_adv   = !clk_en_n && burst_adv && burst_on;
  assign ev_idle  = !clk_en_n && burst_adv && !burst_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_valid <= 1'b0;
      burst_on <= 1'b0;
      ph_op    <= OP_READ;
      ph_addr  <= '0;
      ph_bw_n  <= '1;
    end else if (ev_load) begin
      ph_valid <= 1'b1;
      burst_on <= 1'b1;
      ph_op    <= op_e'(is_read);
      ph_addr  <= addr;
      ph_bw_n  <= lane_we_n;
    end else if (ev_desel) begin
      ph_valid <= 1'b0;
      burst_on <= 1'b0;
    end else if (ev_adv) begin
      ph_valid <= 1'b1;
      ph_addr  <= burst_step(ph_addr);
      ph_bw_n  <= lane_we_n;
    end else if (ev_idle) begin
      ph_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/zbt_wstage.sv
`timescale 1ns/1ps
module zbt_wstage #(
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cap,
  input  logic [AW-1:0]           cap_addr,
  input  logic [LANES-1:0]        cap_bw_n,
  input  logic [LANES*LANE_W-1:0] cap_data,
  output logic                    stg_valid,
  output logic [AW-1:0]           stg_addr,
  output logic [LANES-1:0]        stg_bw_n,
  output logic [LANES*LANE_W-1:0] stg_data,
  output logic                    commit
);
  // A new capture pushes the previous staged write into the array.
  assign commit = cap && stg_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_valid <= 1'b0;
      stg_addr  <= '0;
      stg_bw_n  <= '1;
      stg_data  <= '0;
    end else if (cap) begin
      stg_valid <= 1'b1;
      stg_addr  <= cap_addr;
      stg_bw_n  <= cap_bw_n;
      stg_data  <= cap_data;
    end
  end

endmodule

// File: rtl/zbt_array.sv
`timescale 1ns/1ps
module zbt_array #(
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [LANES-1:0]        wbw_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [AW-1:0]           raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (we && !wbw_n[g]) cells[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = cells[raddr];
  end

endmodule

// File: rtl/zbt_ft_sram.sv
`timescale 1ns/1ps
module zbt_ft_sram #(
  parameter int ADDR_W  = 8,
  parameter int LANES   = 4,
  parameter int LANE_W  = 9,
  parameter int BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_en_n,
  input  logic                    sel_a_n,
  input  logic                    sel_b_n,
  input  logic                    sel_c,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    is_read,
  input  logic                    burst_adv,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic                    out_en_n,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_drive
);
  import zbt_pkg::*;

  localparam int DW = LANES * LANE_W;

  // Lanes with an active-low enable of 0 take the newer word.
  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_w,
                                               input logic [DW-1:0] new_w,
                                               input logic [LANES-1:0] bw_n);
    logic [DW-1:0] r;
    r = old_w;
    for (int i = 0; i < LANES; i++) begin
      if (!bw_n[i]) r[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
    end
    return r;
  endfunction

  logic              ph_valid;
  op_e               ph_op;
  logic [ADDR_W-1:0] ph_addr;
  logic [LANES-1:0]  ph_bw_n;
  logic              burst_on;
  logic              ev_desel;
  logic              ph_is_read;
  logic              wr_cap;

  logic              stg_valid;
  logic [ADDR_W-1:0] stg_addr;
  logic [LANES-1:0]  stg_bw_n;
  logic [DW-1:0]     stg_data;
  logic              commit;

  logic [DW-1:0]     arr_q;
  logic              fwd_hit;

  zbt_ctrl #(
    .AW(ADDR_W), .LANES(LANES), .BURST_W(BURST_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en_n  (clk_en_n),
    .sel_a_n   (sel_a_n),
    .sel_b_n   (sel_b_n),
    .sel_c     (sel_c),
    .addr      (addr),
    .is_read   (is_read),
    .burst_adv (burst_adv),
    .lane_we_n (lane_we_n),
    .ph_valid  (ph_valid),
    .ph_op     (ph_op),
    .ph_addr   (ph_addr),
    .ph_bw_n   (ph_bw_n),
    .burst_on  (burst_on),
    .ev_desel  (ev_desel)
  );

  assign ph_is_read = (ph_op == OP_READ);
  // Write data is taken at the edge that ends its data phase, if that edge is enabled.
  assign wr_cap     = !clk_en_n && ph_valid && !ph_is_read;

  zbt_wstage #(
    .AW(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)
  ) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap       (wr_cap),
    .cap_addr  (ph_addr),
    .cap_bw_n  (ph_bw_n),
    .cap_data  (dq_in),
    .stg_valid (stg_valid),
    .stg_addr  (stg_addr),
    .stg_bw_n  (stg_bw_n),
    .stg_data  (stg_data),
    .commit    (commit)
  );

  zbt_array #(
    .AW(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)
  ) u_array (
    .clk   (clk),
    .we    (commit),
    .waddr (stg_addr),
    .wbw_n (stg_bw_n),
    .wdata (stg_data),
    .raddr (ph_addr),
    .rdata (arr_q)
  );

  assign fwd_hit  = stg_valid && (stg_addr == ph_addr);
  assign dq_out   = fwd_hit ? lane_merge(arr_q, stg_data, stg_bw_n) : arr_q;
  assign dq_drive = ph_valid && ph_is_read && !out_en_n;

endmodule

// File: rtl/zbt_ft_sram_chk.sv
`timescale 1ns/1ps
module zbt_ft_sram_chk #(
  parameter int AW      = 8,
  parameter int BURST_W = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_en_n,
  input logic          sel_a_n,
  input logic          sel_b_n,
  input logic          sel_c,
  input logic [AW-1:0] addr,
  input logic          is_read,
  input logic          burst_adv,
  input logic          out_en_n,
  input logic          dq_drive,
  input logic          ph_valid,
  input logic          ph_is_read,
  input logic [AW-1:0] ph_addr,
  input logic          burst_on,
  input logic          ev_desel,
  input logic          stg_valid,
  input logic [AW-1:0] stg_addr
);
  logic port_sel;
  assign port_sel = !sel_a_n && !sel_b_n && sel_c;

  assert_load_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !burst_adv && port_sel) |=>
      (ph_valid && ph_addr == $past(addr) && ph_is_read == $past(is_read)));

  assert_read_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !burst_adv && port_sel && is_read) |=> (out_en_n || dq_drive));

  assert_write_staged_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && ph_valid && !ph_is_read) |=> (stg_valid && stg_addr == $past(ph_addr)));

  assert_unselected_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !burst_adv && !port_sel) |=> !ph_valid);

  assert_desel_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_desel |=> !dq_drive);

  always @(posedge clk) begin
    if (!rst_n) assert_reset_quiet_R7: assert (!dq_drive);
  end

  assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(ph_valid) && $stable(ph_addr) && $stable(ph_is_read)
                  && $stable(stg_valid) && $stable(stg_addr) && $stable(burst_on)));

  assert_burst_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && burst_adv && burst_on) |=>
      (ph_valid && $stable(ph_is_read)
       && ph_addr[AW-1:BURST_W] == $past(ph_addr[AW-1:BURST_W])
       && ph_addr[BURST_W-1:0] == BURST_W'($past(ph_addr[BURST_W-1:0]) + BURST_W'(1))));

  assert_adv_no_burst_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && burst_adv && !burst_on) |=> !ph_valid);

  assert_oe_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !dq_drive);

endmodule

bind zbt_ft_sram zbt_ft_sram_chk #(
  .AW(ADDR_W), .BURST_W(BURST_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clk_en_n   (clk_en_n),
  .sel_a_n    (sel_a_n),
  .sel_b_n    (sel_b_n),
  .sel_c      (sel_c),
  .addr       (addr),
  .is_read    (is_read),
  .burst_adv  (burst_adv),
  .out_en_n   (out_en_n),
  .dq_drive   (dq_drive),
  .ph_valid   (ph_valid),
  .ph_is_read (ph_is_read),
  .ph_addr    (ph_addr),
  .burst_on   (burst_on),
  .ev_desel   (ev_desel),
  .stg_valid  (stg_valid),
  .stg_addr   (stg_addr)
);

// File: tb/tb_zbt_ft_sram.sv
`timescale 1ns/1ps
module tb_zbt_ft_sram;
  localparam int AW = 4;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clk_en_n, sel_a_n, sel_b_n, sel_c;
  logic [AW-1:0] addr;
  logic          is_read, burst_adv;
  logic [NL-1:0] lane_we_n;
  logic          out_en_n;
  logic [DW-1:0] dq_in;
  logic [DW-1:0] dq_out;
  logic          dq_drive;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // Reference model state
  logic [DW-1:0] mdl [1<<AW];
  logic          m_valid = 1'b0, m_rd = 1'b0, m_burst = 1'b0;
  logic [AW-1:0] m_addr = '0;
  logic [NL-1:0] m_bw = '1;
  string         m_tag = "R7";

  always #5 clk = ~clk;

  zbt_ft_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW), .BURST_W(2)) dut (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel_a_n(sel_a_n),
    .sel_b_n(sel_b_n), .sel_c(sel_c), .addr(addr), .is_read(is_read),
    .burst_adv(burst_adv), .lane_we_n(lane_we_n), .out_en_n(out_en_n),
    .dq_in(dq_in), .dq_out(dq_out), .dq_drive(dq_drive)
  );

  function automatic logic [DW-1:0] rnd_word();
    logic [63:0] r;
    r = {$urandom(), $urandom()};
    return r[DW-1:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Model of one enabled edge, written from the requirements.
  task automatic model_edge(input string tag);
    logic s, prev_wr;
    logic [AW-1:0] prev_addr;
    string auto_tag;
    if (clk_en_n) return;                         // R8: edge ignored
    prev_wr   = m_valid && !m_rd;
    prev_addr = m_addr;
    if (prev_wr) begin                            // R3: lane-wise store
      for (int l = 0; l < NL; l++)
        if (!m_bw[l]) mdl[m_addr][l*LW +: LW] = dq_in[l*LW +: LW];
    end
    if (!burst_adv) begin
      s = !sel_a_n && !sel_b_n && sel_c;          // R4
      m_valid = s; m_burst = s;
      if (s) begin m_rd = is_read; m_addr = addr; m_bw = lane_we_n; end
      if (!s) auto_tag = "R5";
      else if (is_read && prev_wr && prev_addr == addr) auto_tag = "R6";
      else auto_tag = is_read ? "R2" : "R3";
    end else if (m_burst) begin                   // R9
      m_valid = 1'b1;
      m_addr  = {m_addr[AW-1:2], 2'(m_addr[1:0] + 2'd1)};
      m_bw    = lane_we_n;
      auto_tag = "R9";
    end else begin                                // R10
      m_valid = 1'b0;
      auto_tag = "R10";
    end
    m_tag = (tag != "") ? tag : auto_tag;
  endtask

  // One cycle: entered at a falling edge with inputs set; checks just before the rising edge.
  task automatic tick(input string tag);
    logic exp_oe;
    string t;
    dq_in = rnd_word();
    #4;
    exp_oe = m_valid && m_rd && !out_en_n;
    t = (m_valid && m_rd && out_en_n) ? "R11" : m_tag;
    chk(dq_drive === exp_oe, t, DW'(dq_drive), DW'(exp_oe));
    if (exp_oe) chk(dq_out === mdl[m_addr], m_tag, dq_out, mdl[m_addr]);
    @(posedge clk);
    model_edge(tag);
    @(negedge clk);
  endtask

  task automatic ld(input bit rd, input logic [AW-1:0] a, input logic [NL-1:0] bw, input string tag);
    clk_en_n = 1'b0; burst_adv = 1'b0;
    sel_a_n = 1'b0; sel_b_n = 1'b0; sel_c = 1'b1;
    is_read = rd; addr = a; lane_we_n = bw;
    tick(tag);
  endtask

  task automatic desel(input logic [2:0] ce, input string tag);
    clk_en_n = 1'b0; burst_adv = 1'b0;
    {sel_a_n, sel_b_n, sel_c} = ce;
    is_read = 1'($urandom()); addr = AW'($urandom()); lane_we_n = NL'($urandom());
    tick(tag);
  endtask

  task automatic adv(input logic [NL-1:0] bw, input string tag);
    clk_en_n = 1'b0; burst_adv = 1'b1;
    {sel_a_n, sel_b_n, sel_c} = 3'($urandom());  // ignored while advancing
    is_read = 1'($urandom()); addr = AW'($urandom()); lane_we_n = bw;
    tick(tag);
  endtask

  task automatic hold(input string tag);
    clk_en_n = 1'b1; burst_adv = 1'($urandom());
    {sel_a_n, sel_b_n, sel_c} = 3'($urandom());
    is_read = 1'($urandom()); addr = AW'($urandom()); lane_we_n = NL'($urandom());
    tick(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed_v;
    seed_v = $urandom(20240611);
    rst_n = 1'b0; clk_en_n = 1'b0; burst_adv = 1'b0;
    sel_a_n = 1'b1; sel_b_n = 1'b0; sel_c = 1'b1;
    addr = '0; is_read = 1'b1; lane_we_n = '1; out_en_n = 1'b0; dq_in = '0;
    for (int i = 0; i < (1<<AW); i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    chk(dq_drive === 1'b0, "R7", DW'(dq_drive), '0);  // R7 in reset
    rst_n = 1'b1;
    desel(3'b101, "R7");
    desel(3'b101, "R7");

    // R3: fill every word with full-lane writes, back to back
    for (int i = 0; i < (1<<AW); i++) ld(1'b0, AW'(i), 4'b0000, "R3");
    desel(3'b111, "R5");
    // R1/R2: back-to-back reads of every word
    for (int i = 0; i < (1<<AW); i++) ld(1'b1, AW'(i), 4'b1111, "R1");

    // R3/R6: partial write (lanes 0 and 2) then an immediate read of the same word
    ld(1'b0, 4'd3, 4'b1010, "R3");
    ld(1'b1, 4'd3, 4'b1111, "R6");
    ld(1'b0, 4'd3, 4'b0101, "R3");
    ld(1'b0, 4'd3, 4'b1110, "R3");
    ld(1'b1, 4'd3, 4'b1111, "R6");

    // R4: each failing select deselects
    desel(3'b101, "R4");
    desel(3'b011, "R4");
    desel(3'b000, "R4");
    ld(1'b1, 4'd7, 4'b1111, "R4");

    // R6: read, deselect, write, read, write on consecutive edges
    desel(3'b110, "R5");
    ld(1'b1, 4'd8, 4'b1111, "R6");
    ld(1'b0, 4'd8, 4'b0000, "R6");
    ld(1'b1, 4'd8, 4'b1111, "R6");
    desel(3'b100, "R5");
    ld(1'b0, 4'd9, 4'b0011, "R6");
    ld(1'b1, 4'd9, 4'b1111, "R6");

    // R8: frozen edges during a read and during a pending write
    ld(1'b1, 4'd5, 4'b1111, "R8");
    hold("R8");
    hold("R8");
    ld(1'b0, 4'd5, 4'b0000, "R8");
    hold("R8");
    ld(1'b1, 4'd5, 4'b1111, "R8");

    // R9: read burst from 6 wraps 7,4,5; write burst from 9 with varying lanes
    ld(1'b1, 4'd6, 4'b1111, "R9");
    for (int i = 0; i < 4; i++) adv(4'b1111, "R9");
    ld(1'b0, 4'd9, 4'b0000, "R9");
    adv(4'b1100, "R9");
    adv(4'b0110, "R9");
    adv(4'b0000, "R9");
    ld(1'b1, 4'd8, 4'b1111, "R9");
    for (int i = 0; i < 4; i++) adv(4'b0000, "R9");

    // R10: advancing after a deselect stays idle
    desel(3'b111, "R10");
    adv(4'b0000, "R10");
    adv(4'b0000, "R10");

    // R11: output enable high blocks the drive but leaves the burst going
    ld(1'b1, 4'd12, 4'b1111, "R11");
    out_en_n = 1'b1;
    adv(4'b1111, "R11");
    out_en_n = 1'b0;
    adv(4'b1111, "R11");
    ld(1'b1, 4'd12, 4'b1111, "R11");

    // Constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      int k;
      logic [2:0] c;
      k = $urandom_range(0, 99);
      out_en_n = ($urandom_range(0, 9) == 0);
      if (k < 8) hold("");
      else if (k < 30) adv(NL'($urandom()), "");
      else if (k < 42) begin
        c = 3'($urandom());
        if (c == 3'b001) c = 3'b101;
        desel(c, "");
      end else ld($urandom_range(0, 1) == 1, AW'($urandom()), NL'($urandom()), "");
    end
    out_en_n = 1'b0;
    desel(3'b111, "R5");
    desel(3'b111, "R5");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule